// File: doc/BRIEF.md
# Spike Output Packet Assembler

This block gathers spike events produced by a neuron engine during one simulation timestep and packs them into fixed 512-bit records for a host-bound output stream. Each event carries a 17-bit neuron identifier and a 6-bit sub-timestep. Events are stored in arrival order in a packet of up to 14 slots. Every record starts with a constant tag and the number of occupied slots, and it ends with the value of the block's own timestep counter.

A record leaves the block as soon as its last slot is taken, without waiting for the timestep to close. When the engine signals the end of a timestep with a single-cycle pulse, any partly filled record is sent. If no spike occurred in that timestep, nothing is sent. In both cases the timestep counter then advances by one. Events enter on a valid/ready stream and records leave on a valid/ready stream. When the output is stalled, the input stalls with it, so no spike is dropped.

Top module: `spike_packet_assembler`

## Requirements
- R1: Bits [511:496] of every emitted record hold the constant 16'hEEEE.
- R2: Bits [495:480] of every emitted record hold the number of occupied slots, between 1 and 14.
- R3: Slot k (k = 0..13) occupies bits [32+32k+31 : 32+32k]. In an occupied slot, bit 23 is 1, bits [22:6] hold the neuron ID, bits [5:0] hold the sub-timestep, and bits [31:24] are 0. Slots fill from slot 0 in the order the events were accepted.
- R4: Every slot at or beyond the occupied count is all zero, including its bit 23.
- R5: Bits [31:0] hold the timestep counter. The counter is 0 after reset and increases by one each time an end-of-timestep flush completes, including a flush that sends nothing.
- R6: A record is emitted once its 14th slot is filled, without any end-of-timestep pulse.
- R7: On an end-of-timestep pulse, a partly filled record is emitted. An empty one is not emitted. A full record that has already been emitted is not followed by an empty record.
- R8: An event accepted in the same cycle as the end-of-timestep pulse belongs to the timestep that is ending. The input is not ready in the cycle after the pulse, and stays not ready until the flush completes.
- R9: While pkt_valid is high and pkt_ready is low, pkt_valid stays high and pkt_data does not change.
- R10: While the output is stalled and the collecting record is full, ev_ready is low. Every accepted event appears in exactly one emitted record.
- R11: After reset, pkt_valid is low and ev_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Spike event offered |
| ev_ready | output | 1 | Spike event can be taken |
| ev_nid | input | 17 | Neuron ID of the event |
| ev_sub | input | 6 | Sub-timestep of the event |
| eot | input | 1 | One-cycle end-of-timestep pulse |
| pkt_valid | output | 1 | Record offered on output |
| pkt_ready | input | 1 | Downstream accepts the record |
| pkt_data | output | 64+32*SLOTS (512) | Packed output record |

## Verification
The bench builds the block with its default of 14 slots, which gives the 512-bit record described above. With that setting the bench can fill an exact record and then a 15th event that spills into a second record. It can also stall the output long enough to hold one record on the output and a second full record in the collector, which makes the input stall observable at the ports. The extreme field values, neuron ID 17'h1FFFF and sub-timestep 6'h3F, are placed in a slot to show that neighbouring fields do not bleed into each other.

// File: rtl/spike_packet_assembler.sv
module spike_packet_assembler #(
  parameter int SLOTS = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_valid,
  output logic                  ev_ready,
  input  logic [16:0]           ev_nid,
  input  logic [5:0]            ev_sub,
  input  logic                  eot,
  output logic                  pkt_valid,
  input  logic                  pkt_ready,
  output logic [64+32*SLOTS-1:0] pkt_data
);
  localparam int NID_W = 17;
  localparam int SUB_W = 6;
  localparam int TS_W  = 32;
  localparam int PKT_W = 64 + 32 * SLOTS;
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [15:0] TAG = 16'hEEEE;

  logic [NID_W-1:0] nid_q [SLOTS];
  logic [SUB_W-1:0] sub_q [SLOTS];
  logic [CNT_W-1:0] fill_q;
  logic             flush_q;
  logic [TS_W-1:0]  ts_q;
  logic [PKT_W-1:0] packed_rec;

  wire full       = (fill_q == CNT_W'(SLOTS));
  wire empty      = (fill_q == '0);
  wire out_free   = !pkt_valid || pkt_ready;
  wire launch     = out_free && (full || (flush_q && !empty));
  wire flush_done = flush_q && (empty || (launch && !full));
  wire accept     = ev_valid && ev_ready;

  assign ev_ready = rst_n && !flush_q && !full;

  always_comb begin
    packed_rec = '0;
    packed_rec[PKT_W-1 -: 16]  = TAG;
    packed_rec[PKT_W-17 -: 16] = 16'(fill_q);
    for (int i = 0; i < SLOTS; i++) begin
      if (CNT_W'(i) < fill_q)
        packed_rec[32+32*i +: 32] = {8'h00, 1'b1, nid_q[i], sub_q[i]};
    end
    packed_rec[TS_W-1:0] = ts_q;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      nid_q[fill_q] <= ev_nid;
      sub_q[fill_q] <= ev_sub;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q    <= '0;
      flush_q   <= 1'b0;
      ts_q      <= '0;
      pkt_valid <= 1'b0;
      pkt_data  <= '0;
    end else begin
      if (launch)      fill_q <= '0;
      else if (accept) fill_q <= fill_q + 1'b1;
      flush_q <= eot || (flush_q && !flush_done);
      if (flush_done)  ts_q <= ts_q + 1'b1;
      if (launch) begin
        pkt_valid <= 1'b1;
        pkt_data  <= packed_rec;
      end else if (pkt_ready) begin
        pkt_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spike_packet_assembler_chk.sv
module spike_packet_assembler_chk #(
  parameter int SLOTS = 14
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ev_ready,
  input logic                   eot,
  input logic                   pkt_valid,
  input logic                   pkt_ready,
  input logic [64+32*SLOTS-1:0] pkt_data
);
  localparam int PKT_W = 64 + 32 * SLOTS;
  wire [15:0] cnt = pkt_data[PKT_W-17 -: 16];

  AST_TAG_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> pkt_data[PKT_W-1 -: 16] == 16'hEEEE); // R1

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (cnt >= 16'd1 && cnt <= 16'(SLOTS))); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data))); // R9

  AST_EOT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !ev_ready); // R8

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    AST_SLOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> pkt_data[32+32*i+24 +: 8] == 8'h00); // R3
    AST_SLOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> pkt_data[32+32*i+23] == (16'(i) < cnt)); // R4
  end
endmodule

bind spike_packet_assembler spike_packet_assembler_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_ready(ev_ready), .eot(eot),
  .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data)
);

// File: tb/spike_packet_assembler_tb.sv
module spike_packet_assembler_tb;
  localparam int PW = 512;
  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, eot = 0, pkt_ready = 1;
  logic [16:0] ev_nid = '0;
  logic [5:0]  ev_sub = '0;
  logic ev_ready, pkt_valid;
  logic [PW-1:0] pkt_data;
  int checks = 0, fails = 0, sent = 0;
  bit done = 0;
  logic [PW-1:0] got[$];

  always #2 clk = ~clk;

  spike_packet_assembler u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_nid(ev_nid), .ev_sub(ev_sub), .eot(eot), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_data(pkt_data));

  always @(negedge clk) if (rst_n && pkt_valid && pkt_ready) got.push_back(pkt_data);

  function automatic logic [16:0] nid_of(int base, int idx);
    return 17'((base + idx * 4099) % 131072);
  endfunction
  function automatic logic [5:0] sub_of(int base, int idx);
    return 6'((base + idx) % 64);
  endfunction
  function automatic logic [PW-1:0] exp_pkt(int n, int base, int first, logic [31:0] ts);
    logic [PW-1:0] r = '0;
    r[511:496] = 16'hEEEE;
    r[495:480] = 16'(n);
    for (int k = 0; k < n; k++)
      r[32+32*k +: 32] = {8'h00, 1'b1, nid_of(base, first+k), sub_of(base, first+k)};
    r[31:0] = ts;
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [16:0] n, logic [5:0] s);
    ev_valid = 1; ev_nid = n; ev_sub = s;
    #1;
    while (!ev_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    ev_valid = 0;
    sent++;
  endtask

  task automatic send_seq(int base, int first, int n);
    for (int k = 0; k < n; k++) send(nid_of(base, first+k), sub_of(base, first+k));
  endtask

  task automatic pulse_eot();
    eot = 1; @(negedge clk); eot = 0;
  endtask

  task automatic t_reset();
    check(pkt_valid == 0, "R11 pkt_valid after reset", PW'(pkt_valid), 0);
    check(ev_ready == 1, "R11 ev_ready after reset", PW'(ev_ready), 1);
  endtask

  task automatic t_partial();
    logic [PW-1:0] e = exp_pkt(3, 100, 0, 0);
    got.delete();
    send_seq(100, 0, 3);
    cycles(3);
    check(got.size() == 0, "R7 no record before eot", PW'(got.size()), 0);
    pulse_eot(); cycles(4);
    check(got.size() == 1, "R7 partial record on eot", PW'(got.size()), 1);
    if (got.size() > 0) begin
      check(got[0][511:496] == 16'hEEEE, "R1 tag", PW'(got[0][511:496]), 16'hEEEE);
      check(got[0][495:480] == 16'd3, "R2 count", PW'(got[0][495:480]), 3);
      check(got[0][159:128] == 32'h0, "R4 unused slot 3", PW'(got[0][159:128]), 0);
      check(got[0] == e, "R3 slot layout", got[0], e);
    end
  endtask

  task automatic t_empty_then_extreme();
    logic [PW-1:0] e = '0;
    got.delete();
    pulse_eot(); cycles(4);
    check(got.size() == 0, "R7 empty timestep sends nothing", PW'(got.size()), 0);
    send(17'h1FFFF, 6'h3F);
    pulse_eot(); cycles(4);
    e[511:496] = 16'hEEEE; e[495:480] = 16'd1;
    e[63:32] = 32'h00FF_FFFF; e[31:0] = 32'd2;
    check(got.size() == 1, "R5 record after empty flush", PW'(got.size()), 1);
    if (got.size() > 0) begin
      check(got[0][31:0] == 32'd2, "R5 timestep advanced past empty flush", PW'(got[0][31:0]), 2);
      check(got[0] == e, "R3 extreme field values", got[0], e);
    end
  endtask

  task automatic t_full();
    logic [PW-1:0] e = exp_pkt(14, 500, 0, 3);
    got.delete();
    send_seq(500, 0, 14);
    cycles(4);
    check(got.size() == 1, "R6 full record without eot", PW'(got.size()), 1);
    if (got.size() > 0) check(got[0] == e, "R6 full record content", got[0], e);
    pulse_eot(); cycles(4);
    check(got.size() == 1, "R7 no empty record after full", PW'(got.size()), 1);
  endtask

  task automatic t_spill();
    logic [PW-1:0] e0 = exp_pkt(14, 900, 0, 4);
    logic [PW-1:0] e1 = exp_pkt(1, 900, 14, 4);
    got.delete();
    send_seq(900, 0, 15);
    pulse_eot(); cycles(4);
    check(got.size() == 2, "R6 fifteen events give two records", PW'(got.size()), 2);
    if (got.size() == 2) begin
      check(got[0] == e0, "R6 first record", got[0], e0);
      check(got[1] == e1, "R3 spilled event starts at slot 0", got[1], e1);
    end
  endtask

  task automatic t_same_cycle_eot();
    logic [PW-1:0] e = exp_pkt(3, 1300, 0, 5);
    got.delete();
    send_seq(1300, 0, 2);
    ev_valid = 1; ev_nid = nid_of(1300, 2); ev_sub = sub_of(1300, 2); eot = 1;
    #1;
    check(ev_ready == 1, "R8 ready in eot cycle", PW'(ev_ready), 1);
    @(negedge clk);
    ev_valid = 0; eot = 0;
    check(ev_ready == 0, "R8 not ready after eot", PW'(ev_ready), 0);
    cycles(4);
    check(got.size() == 1, "R8 one record", PW'(got.size()), 1);
    if (got.size() > 0) check(got[0] == e, "R8 event with eot in ending timestep", got[0], e);
  endtask

  task automatic t_backpressure();
    logic [PW-1:0] held;
    logic [PW-1:0] e0 = exp_pkt(14, 2000, 0, 6);
    logic [PW-1:0] e1 = exp_pkt(14, 2000, 14, 6);
    logic [PW-1:0] e2 = exp_pkt(1, 2000, 28, 6);
    got.delete();
    pkt_ready = 0;
    sent = 0;
    fork send_seq(2000, 0, 29); join_none
    cycles(70);
    check(sent == 28, "R10 input stalls when full and blocked", PW'(sent), 28);
    check(ev_ready == 0, "R10 ev_ready low", PW'(ev_ready), 0);
    held = pkt_data;
    cycles(5);
    check(pkt_valid == 1 && pkt_data == held, "R9 output held", pkt_data, held);
    pkt_ready = 1;
    wait (sent == 29);
    @(negedge clk);
    pulse_eot(); cycles(5);
    check(got.size() == 3, "R10 no event lost", PW'(got.size()), 3);
    if (got.size() == 3) begin
      check(got[0] == e0, "R10 record 0", got[0], e0);
      check(got[1] == e1, "R10 record 1", got[1], e1);
      check(got[2] == e2, "R10 record 2", got[2], e2);
    end
  endtask

  initial begin
    cycles(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_partial();
    t_empty_then_extreme();
    t_full();
    t_spill();
    t_same_cycle_eot();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule